// File: doc/BRIEF.md
# Sector Decoder Buffer Writer

This block takes in decoded disc sectors one at a time. Each sector is a four-byte header presented with a start strobe, followed by a stream of 2048 data bytes. When decoding is switched on, an accepted sector does three things. It latches the header into the current header registers. It marks the status-3 byte valid. It lowers an active-low decoder interrupt flag.

When the write request is also set, the block moves its block pointer and its write address forward by one raw sector stride of 2352 bytes. It then stores the sector through a byte-wide RAM write port into a 16 KB circular buffer, starting at the new block pointer taken modulo the buffer size. The header bytes go in first and the data bytes follow. A later status-3 read hands the valid mark back and releases the interrupt.

A `busy` output covers the whole store. New sector strobes are not accepted while it is high. The block pointer and the write address can each be preset from outside, so software can place the ring position.

Top module: `sector_buf_writer`

## Requirements
- R1: A sector strobe (`sec_vld`) with `dec_en` low changes nothing: the header latch, status 3, the interrupt flag and both pointers keep their values, and no RAM write occurs.
- R2: An accepted strobe (`sec_vld` with `dec_en` high and `busy` low) loads `hdr_cur` with `sec_hdr` and sets `stat3` to 0x00 (bit 7 low = valid) on the next clock edge.
- R3: An accepted strobe drives `irq_n` to 0 on the next clock edge.
- R4: If `wr_req` is high at an accepted strobe, both `blk_ptr` and `wr_addr` increase by 2352, modulo 65536, on the next edge. If `wr_req` is low, the pointers are unchanged and no RAM write occurs.
- R5: A write sector produces 2052 writes at consecutive addresses. The first address is the new `blk_ptr` bits 13:0. The header bytes come first, most significant byte of `sec_hdr` first, then the data bytes in arrival order. The first header write appears on the port one edge after the accepting edge.
- R6: Write addresses wrap from 0x3FFF to 0x0000 within a single sector.
- R7: A `stat_rd` pulse, with no accepted strobe in the same cycle, sets `stat3` to 0x80 and `irq_n` to 1 on the next edge. `stat3` shows the value being read during the pulse. An accepted strobe in the same cycle takes priority.
- R8: After reset `hdr_cur` is 0x00000001, `hdr_alt` is 0x00000000, `stat3` is 0x80, `irq_n` is 1, `busy` is 0 and both pointers are 0.
- R9: `busy` rises on the edge that accepts a write sector and falls on the edge that samples the last data byte. Strobes that arrive while `busy` is high are ignored: no header, status or pointer change.
- R10: `ptr_ld` loads `blk_ptr` and `wa_ld` loads `wr_addr` from `ld_val` on the next edge, unless an accepted write sector steps that pointer in the same cycle, in which case the step wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_en | input | 1 | Decode enable |
| wr_req | input | 1 | Buffer write request |
| sec_vld | input | 1 | Sector start strobe |
| sec_hdr | input | 32 | Sector header, byte 0 in bits 31:24 |
| dat_vld | input | 1 | Data byte valid |
| dat_byte | input | 8 | Data byte |
| stat_rd | input | 1 | Status-3 read pulse |
| ptr_ld | input | 1 | Load block pointer |
| wa_ld | input | 1 | Load write address |
| ld_val | input | 16 | Preset value |
| busy | output | 1 | Sector store in progress |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 14 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| blk_ptr | output | 16 | Block pointer |
| wr_addr | output | 16 | Write address |
| hdr_cur | output | 32 | Current header latch |
| hdr_alt | output | 32 | Second header set (held at zero) |
| stat3 | output | 8 | Status 3, bit 7 active-low valid |
| irq_n | output | 1 | Active-low decoder interrupt flag |

## Verification
The header latch, status 3, the interrupt flag, `busy` and both pointers all change on the first edge after an accepted strobe. The bench reads them at the falling edge that follows. The header writes reach the RAM port on the four edges after that. Each data byte is written one edge after the edge that samples it. The bench therefore streams data only once the header phase is over, and it waits one extra falling edge before tallying the writes.

A monitor compares every RAM write on the falling edge against an address and byte computed from the sector's base and index. Status reads are checked one edge after the pulse.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA
  } sbw_state_e;

  localparam logic [7:0]  STAT3_IDLE  = 8'h80;
  localparam logic [7:0]  STAT3_VALID = 8'h00;
  localparam logic [31:0] HDR_CUR_RST = 32'h0000_0001;
endpackage

// File: rtl/sbw_ptr_reg.sv
module sbw_ptr_reg #(
  parameter int W      = 16,
  parameter int STRIDE = 2352
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] STEP_V = W'(STRIDE);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (step) q <= q + STEP_V;
    else if (load) q <= load_val;
  end

  assert_stride_step_R4: assert property (@(posedge clk) disable iff (rst)
    step |=> q == $past(q) + STEP_V);
  assert_preset_R10: assert property (@(posedge clk) disable iff (rst)
    (load && !step) |=> q == $past(load_val));
endmodule

// File: rtl/sbw_status.sv
module sbw_status
  import sbw_pkg::*;
#(
  parameter int HDR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [HDR_W-1:0] hdr_in,
  input  logic             stat_rd,
  output logic [HDR_W-1:0] hdr_cur,
  output logic [HDR_W-1:0] hdr_alt,
  output logic [7:0]       stat3,
  output logic             irq_n
);
  assign hdr_alt = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_cur <= HDR_W'(HDR_CUR_RST);
      stat3   <= STAT3_IDLE;
      irq_n   <= 1'b1;
    end else if (accept) begin
      hdr_cur <= hdr_in;
      stat3   <= STAT3_VALID;
      irq_n   <= 1'b0;
    end else if (stat_rd) begin
      stat3   <= STAT3_IDLE;
      irq_n   <= 1'b1;
    end
  end

  assert_hdr_latch_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (hdr_cur == $past(hdr_in)) && (stat3 == STAT3_VALID));
  assert_irq_post_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> !irq_n);
  assert_stat_read_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !accept) |=> (stat3 == STAT3_IDLE) && irq_n);
endmodule

// File: rtl/sbw_writer.sv
module sbw_writer
  import sbw_pkg::*;
#(
  parameter int RAM_AW     = 14,
  parameter int HDR_BYTES  = 4,
  parameter int DATA_BYTES = 2048
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [RAM_AW-1:0]      start_base,
  input  logic [8*HDR_BYTES-1:0] hdr,
  input  logic                   dat_vld,
  input  logic [7:0]             dat_byte,
  output logic                   busy,
  output logic                   ram_we,
  output logic [RAM_AW-1:0]      ram_addr,
  output logic [7:0]             ram_wdata
);
  localparam int HDR_W = 8 * HDR_BYTES;
  localparam int TOTAL = HDR_BYTES + DATA_BYTES;
  localparam int CNT_W = $clog2(TOTAL);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0] ALL_LAST = CNT_W'(TOTAL - 1);

  sbw_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [RAM_AW-1:0] base;
  logic [HDR_W-1:0]  hdr_q;
  logic [RAM_AW-1:0] cur_addr;

  assign cur_addr = base + RAM_AW'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      base      <= '0;
      hdr_q     <= '0;
      busy      <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_HDR;
          busy  <= 1'b1;
          cnt   <= '0;
          base  <= start_base;
          hdr_q <= hdr;
        end
        ST_HDR: begin
          ram_we    <= 1'b1;
          ram_addr  <= cur_addr;
          ram_wdata <= hdr_q[HDR_W-1 -: 8];
          hdr_q     <= {hdr_q[HDR_W-9:0], 8'h00};
          cnt       <= cnt + CNT_W'(1);
          if (cnt == HDR_LAST) state <= ST_DATA;
        end
        ST_DATA: if (dat_vld) begin
          ram_we    <= 1'b1;
          ram_addr  <= cur_addr;
          ram_wdata <= dat_byte;
          cnt       <= cnt + CNT_W'(1);
          if (cnt == ALL_LAST) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_write_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(busy));
  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: rtl/sector_buf_writer.sv
module sector_buf_writer #(
  parameter int PTR_W      = 16,
  parameter int RAM_AW     = 14,
  parameter int STRIDE     = 2352,
  parameter int HDR_BYTES  = 4,
  parameter int DATA_BYTES = 2048
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dec_en,
  input  logic                   wr_req,
  input  logic                   sec_vld,
  input  logic [8*HDR_BYTES-1:0] sec_hdr,
  input  logic                   dat_vld,
  input  logic [7:0]             dat_byte,
  input  logic                   stat_rd,
  input  logic                   ptr_ld,
  input  logic                   wa_ld,
  input  logic [PTR_W-1:0]       ld_val,
  output logic                   busy,
  output logic                   ram_we,
  output logic [RAM_AW-1:0]      ram_addr,
  output logic [7:0]             ram_wdata,
  output logic [PTR_W-1:0]       blk_ptr,
  output logic [PTR_W-1:0]       wr_addr,
  output logic [8*HDR_BYTES-1:0] hdr_cur,
  output logic [8*HDR_BYTES-1:0] hdr_alt,
  output logic [7:0]             stat3,
  output logic                   irq_n
);
  localparam int HDR_W = 8 * HDR_BYTES;
  localparam int NPTR  = 2;

  logic              accept;
  logic              step;
  logic [RAM_AW-1:0] start_base;
  logic [NPTR-1:0]   ld_vec;
  logic [PTR_W-1:0]  ptr_q [NPTR];

  assign accept     = sec_vld && dec_en && !busy;
  assign step       = accept && wr_req;
  assign ld_vec     = {wa_ld, ptr_ld};
  assign start_base = blk_ptr[RAM_AW-1:0] + RAM_AW'(STRIDE);
  assign blk_ptr    = ptr_q[0];
  assign wr_addr    = ptr_q[1];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    sbw_ptr_reg #(.W(PTR_W), .STRIDE(STRIDE)) i_ptr (
      .clk      (clk),
      .rst      (rst),
      .step     (step),
      .load     (ld_vec[g]),
      .load_val (ld_val),
      .q        (ptr_q[g])
    );
  end

  sbw_status #(.HDR_W(HDR_W)) i_status (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .hdr_in  (sec_hdr),
    .stat_rd (stat_rd),
    .hdr_cur (hdr_cur),
    .hdr_alt (hdr_alt),
    .stat3   (stat3),
    .irq_n   (irq_n)
  );

  sbw_writer #(
    .RAM_AW(RAM_AW), .HDR_BYTES(HDR_BYTES), .DATA_BYTES(DATA_BYTES)
  ) i_writer (
    .clk        (clk),
    .rst        (rst),
    .start      (step),
    .start_base (start_base),
    .hdr        (sec_hdr),
    .dat_vld    (dat_vld),
    .dat_byte   (dat_byte),
    .busy       (busy),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata)
  );

  assert_off_no_change_R1: assert property (@(posedge clk) disable iff (rst)
    (sec_vld && !dec_en && !busy) |=> $stable(hdr_cur));
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (sec_vld && busy) |=> $stable(hdr_cur));
  assert_off_no_write_R1: assert property (@(posedge clk) disable iff (rst)
    (sec_vld && !dec_en && !busy) |=> !busy);
endmodule

// File: tb/test_sector_buf_writer.sv
module test_sector_buf_writer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, dec_en = 0, wr_req = 0, sec_vld = 0, dat_vld = 0;
  logic stat_rd = 0, ptr_ld = 0, wa_ld = 0;
  logic [31:0] sec_hdr = '0;
  logic [7:0]  dat_byte = '0;
  logic [15:0] ld_val = '0;
  logic busy, ram_we, irq_n;
  logic [13:0] ram_addr;
  logic [7:0]  ram_wdata, stat3;
  logic [15:0] blk_ptr, wr_addr;
  logic [31:0] hdr_cur, hdr_alt;

  sector_buf_writer i_sector_buf_writer (
    .clk(clk), .rst(rst), .dec_en(dec_en), .wr_req(wr_req), .sec_vld(sec_vld),
    .sec_hdr(sec_hdr), .dat_vld(dat_vld), .dat_byte(dat_byte), .stat_rd(stat_rd),
    .ptr_ld(ptr_ld), .wa_ld(wa_ld), .ld_val(ld_val), .busy(busy), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .blk_ptr(blk_ptr), .wr_addr(wr_addr),
    .hdr_cur(hdr_cur), .hdr_alt(hdr_alt), .stat3(stat3), .irq_n(irq_n)
  );

  // {header[50:19], dec_en[18], wr_req[17], preset[16], preset value[15:0]}
  localparam int NVEC = 6;
  localparam logic [50:0] VEC [NVEC] = '{
    {32'h0102_0304, 1'b1, 1'b1, 1'b0, 16'h0000},
    {32'hAABB_CCDD, 1'b0, 1'b1, 1'b0, 16'h0000},
    {32'h1122_3344, 1'b1, 1'b0, 1'b0, 16'h0000},
    {32'h5566_7788, 1'b1, 1'b1, 1'b1, 16'h35D0},
    {32'h99AA_BBCC, 1'b1, 1'b1, 1'b1, 16'hF700},
    {32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 16'h0000}
  };

  int n_cmp = 0, n_bad = 0;
  int mon_idx = 0, mon_bad = 0;
  logic [13:0] mon_base = '0;
  logic [31:0] mon_hdr = '0;
  logic [15:0] eptr = '0, ewa = '0;
  logic [31:0] ehdr = 32'h1;

  function automatic logic [7:0] pat(input logic [31:0] h, input int i);
    logic [10:0] k = 11'(i);
    return (k[7:0] + h[15:8]) ^ {5'd0, k[10:8]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // RAM write monitor: address and byte expected from base + index
  always @(negedge clk) begin
    if (ram_we) begin
      logic [13:0] ea;
      logic [7:0]  ed;
      ea = mon_base + 14'(mon_idx);
      ed = (mon_idx < 4) ? mon_hdr[31 - 8*mon_idx -: 8] : pat(mon_hdr, mon_idx - 4);
      if (ram_addr !== ea || ram_wdata !== ed) mon_bad++;
      mon_idx++;
    end
  end

  task automatic stream(input logic [31:0] h, input int intr_at);
    for (int j = 0; j < 2048; j++) begin
      dat_vld  = 1'b1;
      dat_byte = pat(h, j);
      sec_vld  = (j == intr_at);
      if (j == intr_at) sec_hdr = 32'hCAFE_F00D;
      @(negedge clk);
      if (j == intr_at) begin
        chk("R9 busy held", {31'd0, busy}, 32'd1);
        chk("R9 hdr kept", hdr_cur, h);
        chk("R9 ptr kept", {16'd0, blk_ptr}, {16'd0, eptr});
      end
    end
    dat_vld = 1'b0;
    sec_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] h, input logic de, input logic wr);
    mon_idx  = 0;
    mon_bad  = 0;
    mon_hdr  = h;
    mon_base = eptr[13:0] + 14'd2352;
    sec_hdr  = h;
    dec_en   = de;
    wr_req   = wr;
    sec_vld  = 1'b1;
    @(negedge clk);
    sec_vld = 1'b0;
    if (de) ehdr = h;
    if (de && wr) begin
      eptr = eptr + 16'd2352;
      ewa  = ewa + 16'd2352;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk("R8 hdr_cur", hdr_cur, 32'h0000_0001);
    chk("R8 hdr_alt", hdr_alt, 32'h0);
    chk("R8 stat3", {24'd0, stat3}, 32'h80);
    chk("R8 irq_n", {31'd0, irq_n}, 32'd1);
    chk("R8 busy", {31'd0, busy}, 32'd0);
    chk("R8 ptr", {blk_ptr, wr_addr}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] h;
      logic de, wr, ld;
      logic [15:0] lv;
      logic [7:0] est3;
      {h, de, wr, ld, lv} = VEC[v];
      if (ld) begin
        ptr_ld = 1'b1;
        wa_ld  = 1'b1;
        ld_val = lv;
        @(negedge clk);
        ptr_ld = 1'b0;
        wa_ld  = 1'b0;
        eptr   = lv;
        ewa    = lv;
        chk("R10 preset", {blk_ptr, wr_addr}, {lv, lv});
      end
      send(h, de, wr);
      est3 = de ? 8'h00 : 8'h80;
      chk(de ? "R2 hdr latch" : "R1 hdr unchanged", hdr_cur, ehdr);
      chk(de ? "R2 stat3 valid" : "R1 stat3 unchanged", {24'd0, stat3}, {24'd0, est3});
      chk(de ? "R3 irq posted" : "R1 irq unchanged", {31'd0, irq_n}, {31'd0, !de});
      chk("R4 blk_ptr", {16'd0, blk_ptr}, {16'd0, eptr});
      chk("R4 wr_addr", {16'd0, wr_addr}, {16'd0, ewa});
      chk("R9 busy rise", {31'd0, busy}, {31'd0, de && wr});
      if (de && wr) begin
        repeat (4) @(negedge clk);
        stream(h, -1);
        chk("R9 busy fall", {31'd0, busy}, 32'd0);
        chk("R5 write count", mon_idx, 2052);
        chk(ld ? "R6 wrapped writes" : "R5 write order", mon_bad, 0);
      end else begin
        repeat (3) @(negedge clk);
        chk(de ? "R4 no write" : "R1 no write", mon_idx, 0);
      end
      chk("R7 read value", {24'd0, stat3}, {24'd0, est3});
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
      chk("R7 stat3 idle", {24'd0, stat3}, 32'h80);
      chk("R7 irq released", {31'd0, irq_n}, 32'd1);
    end

    // R9 directed: strobe during a store is ignored
    send(32'h0BAD_F00D, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    stream(32'h0BAD_F00D, 100);
    chk("R9 hdr after store", hdr_cur, 32'h0BAD_F00D);
    chk("R9 single step", {16'd0, blk_ptr}, {16'd0, eptr});
    chk("R9 writes intact", mon_bad, 0);
    chk("R9 write count", mon_idx, 2052);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule